// File: doc/BRIEF.md
# Speculative L1 Violation Tracker

This block sits beside the tag array of one processor's small data cache in a chip multiprocessor that runs threads speculatively. For every line it holds a valid bit, a tag, a read marker set by local loads, a modified marker set by local stores, and a deferred-invalidate flag. It watches a shared write-bus snoop port whose broadcasts carry the writer's thread sequence number. Each remote write is sorted as older or younger than the local thread, and the block acts on that order.

A write from an older thread removes the matching line so that the local thread fetches the forwarded value again. If the local thread had already loaded from that line, the block also reports a dependency violation. A write from a younger thread does not touch the line yet. The line is only flagged, and the flagged lines are dropped when the local thread commits. A restart drops every line that the thread wrote speculatively. Data arrays, the shared cache and the thread sequencer are outside this block.

Top module: `spec_viol_tracker`

## Requirements
- R1: After reset every line is invalid (`lk_hit_o` is 0 for any index and tag) and `viol_o` is 0.
- R2: `lk_hit_o` is a combinational compare of the line at `lk_idx_i` (valid and tag equal to `lk_tag_i`) and does not depend on `lk_valid_i`. An access (`lk_valid_i`=1) makes the line valid with `lk_tag_i` at the next clock edge. `lk_store_i`=1 sets the modified marker and `lk_store_i`=0 sets the read marker. A tag change clears the old markers first.
- R3: Thread age is taken relative to `head_seq_i` as (seq - head_seq_i) modulo 2^SEQ_W. A writer whose relative age is smaller than that of `my_seq_i` is older, and a writer whose relative age is larger is younger. This ordering holds across wrap-around.
- R4: A snoop from an older thread that hits a valid line invalidates that line at the next edge.
- R5: A snoop from an older thread that hits a line with its read marker set raises `viol_o` in the cycle after the snoop edge. A hit on a line that only has its modified marker set raises no violation.
- R6: A snoop from a younger thread leaves the line valid and sets only its deferred-invalidate flag. It raises no violation.
- R7: On `commit_i`, every flagged line is invalidated, and all read markers, modified markers and flags are cleared in that one cycle. An unflagged line stays valid.
- R8: On `restart_i`, every line with its modified marker set is invalidated and all read markers are cleared. Other lines and their deferred-invalidate flags are kept.
- R9: A snoop whose sequence number equals `my_seq_i` has no effect on any line and raises no violation.
- R10: `viol_o` is a single-cycle pulse. After a pulse, further violations are masked until `restart_i` is asserted.
- R11: `restart_i` takes priority over `commit_i`. Lookups and snoops presented in a cycle with either control asserted are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| my_seq_i | input | SEQ_W | Sequence number of the local thread |
| head_seq_i | input | SEQ_W | Sequence number of the oldest, non-speculative thread |
| lk_valid_i | input | 1 | Local access strobe |
| lk_store_i | input | 1 | Access is a store (1) or a load (0) |
| lk_idx_i | input | IDX_W | Line index of the access or probe |
| lk_tag_i | input | TAG_W | Tag of the access or probe |
| lk_hit_o | output | 1 | Line at lk_idx_i is valid with matching tag |
| snp_valid_i | input | 1 | Write-bus broadcast strobe |
| snp_seq_i | input | SEQ_W | Writer's thread sequence number |
| snp_idx_i | input | IDX_W | Line index of the written address |
| snp_tag_i | input | TAG_W | Tag of the written address |
| commit_i | input | 1 | Local thread completes |
| restart_i | input | 1 | Local thread restarts; unmasks violations |
| viol_o | output | 1 | Dependency violation pulse |

## Verification
The bench places the head pointer away from zero so that an age comparison with no wrap-around would sort writers wrongly. It checks that a store-only line hit by an older write is dropped without a violation, which catches a design that treats the modified marker as a read. It checks that a second violation before restart stays silent and that one after restart pulses again, which catches a missing mask and a mask that is never cleared. It also checks that deferred flags survive a restart and take effect only at commit, that markers cleared by a commit cause no later violation or invalidation, and that an access made during a restart cycle is dropped.

// File: rtl/spec_trk_pkg.sv
package spec_trk_pkg;
  typedef enum logic [1:0] {
    SNP_OWN     = 2'd0,
    SNP_EARLIER = 2'd1,
    SNP_LATER   = 2'd2
  } snp_cls_e;
endpackage

// File: rtl/sv_seq_order.sv
module sv_seq_order
  import spec_trk_pkg::*;
#(
  parameter int SEQ_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEQ_W-1:0] head_seq_i,
  input  logic [SEQ_W-1:0] my_seq_i,
  input  logic [SEQ_W-1:0] snp_seq_i,
  output snp_cls_e         cls_o
);
  logic [SEQ_W-1:0] rel_my, rel_snp;

  // age relative to head, modulo 2^SEQ_W
  assign rel_my  = my_seq_i - head_seq_i;
  assign rel_snp = snp_seq_i - head_seq_i;

  always_comb begin
    if (rel_snp < rel_my)      cls_o = SNP_EARLIER;
    else if (rel_snp > rel_my) cls_o = SNP_LATER;
    else                       cls_o = SNP_OWN;
  end

  // R9
  own_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_seq_i == my_seq_i) |-> (cls_o == SNP_OWN));
endmodule

// File: rtl/sv_line_slot.sv
module sv_line_slot
  import spec_trk_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             commit_i,
  input  logic             acc_en_i,
  input  logic             acc_store_i,
  input  logic [TAG_W-1:0] acc_tag_i,
  input  logic             snp_en_i,
  input  snp_cls_e         snp_cls_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  input  logic [TAG_W-1:0] probe_tag_i,
  output logic             probe_hit_o,
  output logic             viol_o
);
  logic             valid_q, rd_q, md_q, pre_q;
  logic [TAG_W-1:0] tag_q;
  logic             valid_d, rd_d, md_d, pre_d;
  logic [TAG_W-1:0] tag_d;
  logic             snp_hit;

  assign probe_hit_o = valid_q && (tag_q == probe_tag_i);

  always_comb begin
    valid_d = valid_q; tag_d = tag_q;
    rd_d = rd_q; md_d = md_q; pre_d = pre_q;
    snp_hit = 1'b0;
    viol_o  = 1'b0;
    if (restart_i) begin
      if (md_q) valid_d = 1'b0;
      rd_d = 1'b0;
      md_d = 1'b0;
    end else if (commit_i) begin
      if (pre_q) valid_d = 1'b0;
      rd_d = 1'b0; md_d = 1'b0; pre_d = 1'b0;
    end else begin
      if (acc_en_i) begin
        if (!(valid_q && tag_q == acc_tag_i)) begin
          valid_d = 1'b1; tag_d = acc_tag_i;
          rd_d = 1'b0; md_d = 1'b0; pre_d = 1'b0;
        end
        if (acc_store_i) md_d = 1'b1;
        else             rd_d = 1'b1;
      end
      // snoop sees this cycle's access result
      snp_hit = snp_en_i && valid_d && (tag_d == snp_tag_i);
      if (snp_hit && snp_cls_i == SNP_EARLIER) begin
        viol_o  = rd_d;
        valid_d = 1'b0;
        rd_d = 1'b0; md_d = 1'b0; pre_d = 1'b0;
      end else if (snp_hit && snp_cls_i == SNP_LATER) begin
        pre_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0; tag_q <= '0;
      rd_q <= 1'b0; md_q <= 1'b0; pre_q <= 1'b0;
    end else begin
      valid_q <= valid_d; tag_q <= tag_d;
      rd_q <= rd_d; md_q <= md_d; pre_q <= pre_d;
    end
  end

  // R8
  restart_md_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!md_q && !rd_q));
  // R7
  commit_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !restart_i) |=> (!rd_q && !md_q && !pre_q));
  // R6
  later_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !commit_i && !acc_en_i && snp_en_i && snp_cls_i == SNP_LATER
     && valid_q && tag_q == snp_tag_i) |=> (valid_q && pre_q));
  // R4
  earlier_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !commit_i && !acc_en_i && snp_en_i && snp_cls_i == SNP_EARLIER
     && valid_q && tag_q == snp_tag_i) |=> !valid_q);
endmodule

// File: rtl/sv_viol_ctrl.sv
module sv_viol_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic viol_raw_i,
  input  logic restart_i,
  output logic viol_o
);
  logic viol_q, mask_q;

  assign viol_o = viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q <= 1'b0;
      mask_q <= 1'b0;
    end else if (restart_i) begin
      viol_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      viol_q <= viol_raw_i && !mask_q;
      if (viol_raw_i) mask_q <= 1'b1;
    end
  end

  // R10
  viol_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> !viol_o);
  // R10
  viol_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q && !restart_i) |=> !viol_o);
endmodule

// File: rtl/spec_viol_tracker.sv
module spec_viol_tracker
  import spec_trk_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TAG_W = 8,
  parameter int SEQ_W = 2,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEQ_W-1:0] my_seq_i,
  input  logic [SEQ_W-1:0] head_seq_i,
  input  logic             lk_valid_i,
  input  logic             lk_store_i,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             lk_hit_o,
  input  logic             snp_valid_i,
  input  logic [SEQ_W-1:0] snp_seq_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  input  logic             commit_i,
  input  logic             restart_i,
  output logic             viol_o
);
  snp_cls_e         snp_cls;
  logic [LINES-1:0] hit_vec, viol_vec;

  sv_seq_order #(.SEQ_W(SEQ_W)) u_order (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .head_seq_i (head_seq_i),
    .my_seq_i   (my_seq_i),
    .snp_seq_i  (snp_seq_i),
    .cls_o      (snp_cls)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_line
    sv_line_slot #(.TAG_W(TAG_W)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .restart_i   (restart_i),
      .commit_i    (commit_i),
      .acc_en_i    (lk_valid_i && (lk_idx_i == IDX_W'(g))),
      .acc_store_i (lk_store_i),
      .acc_tag_i   (lk_tag_i),
      .snp_en_i    (snp_valid_i && (snp_idx_i == IDX_W'(g))),
      .snp_cls_i   (snp_cls),
      .snp_tag_i   (snp_tag_i),
      .probe_tag_i (lk_tag_i),
      .probe_hit_o (hit_vec[g]),
      .viol_o      (viol_vec[g])
    );
  end

  assign lk_hit_o = hit_vec[lk_idx_i];

  sv_viol_ctrl u_viol (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .viol_raw_i (|viol_vec),
    .restart_i  (restart_i),
    .viol_o     (viol_o)
  );

  // R11
  ctrl_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i || commit_i) |=> !viol_o);
  // R5
  single_viol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(viol_vec) <= 1);
endmodule

// File: tb/spec_viol_tracker_tb_top.sv
module spec_viol_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 16;
  localparam int TAG_W = 8;
  localparam int SEQ_W = 2;
  localparam int IDX_W = $clog2(LINES);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [SEQ_W-1:0] my_seq = 2'd1, head_seq = 2'd0;
  logic             lk_valid = 1'b0, lk_store = 1'b0;
  logic [IDX_W-1:0] lk_idx = '0;
  logic [TAG_W-1:0] lk_tag = '0;
  logic             lk_hit;
  logic             snp_valid = 1'b0;
  logic [SEQ_W-1:0] snp_seq = '0;
  logic [IDX_W-1:0] snp_idx = '0;
  logic [TAG_W-1:0] snp_tag = '0;
  logic             commit = 1'b0, restart = 1'b0;
  logic             viol;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_viol_tracker #(.LINES(LINES), .TAG_W(TAG_W), .SEQ_W(SEQ_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .my_seq_i(my_seq), .head_seq_i(head_seq),
    .lk_valid_i(lk_valid), .lk_store_i(lk_store), .lk_idx_i(lk_idx),
    .lk_tag_i(lk_tag), .lk_hit_o(lk_hit), .snp_valid_i(snp_valid),
    .snp_seq_i(snp_seq), .snp_idx_i(snp_idx), .snp_tag_i(snp_tag),
    .commit_i(commit), .restart_i(restart), .viol_o(viol));

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic access(input int idx, input int tag, input logic st);
    @(negedge clk);
    lk_valid = 1'b1; lk_store = st;
    lk_idx = IDX_W'(idx); lk_tag = TAG_W'(tag);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic snoop(input int seq, input int idx, input int tag);
    @(negedge clk);
    snp_valid = 1'b1; snp_seq = SEQ_W'(seq);
    snp_idx = IDX_W'(idx); snp_tag = TAG_W'(tag);
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic do_restart();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
  endtask

  task automatic do_commit();
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
  endtask

  task automatic probe(input int idx, input int tag, input logic exp, input string req);
    lk_idx = IDX_W'(idx); lk_tag = TAG_W'(tag);
    #1;
    chk(lk_hit, exp, req);
  endtask

  task automatic t_reset();
    for (int i = 0; i < LINES; i++) probe(i, 0, 1'b0, "R1 line invalid");
    chk(viol, 1'b0, "R1 viol low");
  endtask

  task automatic t_lookup();
    access(3, 'h11, 1'b0);
    probe(3, 'h11, 1'b1, "R2 hit after load");
    probe(3, 'h12, 1'b0, "R2 tag mismatch");
  endtask

  task automatic t_earlier();
    do_restart();
    access(3, 'h11, 1'b0);
    snoop(0, 3, 'h11);
    chk(viol, 1'b1, "R5 older write on read line");
    @(negedge clk);
    chk(viol, 1'b0, "R10 one-cycle pulse");
    probe(3, 'h11, 1'b0, "R4 line invalidated");
    access(4, 'h22, 1'b0);
    snoop(0, 4, 'h22);
    chk(viol, 1'b0, "R10 masked second violation");
    probe(4, 'h22, 1'b0, "R4 invalidated while masked");
    do_restart();
    access(3, 'h11, 1'b0);
    snoop(0, 3, 'h11);
    chk(viol, 1'b1, "R10 unmasked after restart");
  endtask

  task automatic t_store_only();
    do_restart();
    access(5, 'h33, 1'b1);
    snoop(0, 5, 'h33);
    chk(viol, 1'b0, "R5 store-only line no violation");
    probe(5, 'h33, 1'b0, "R4 store-only line invalidated");
  endtask

  task automatic t_later_commit();
    do_restart();
    access(6, 'h44, 1'b0);
    access(7, 'h45, 1'b0);
    snoop(2, 6, 'h44);
    chk(viol, 1'b0, "R6 younger write no violation");
    probe(6, 'h44, 1'b1, "R6 line kept valid");
    do_commit();
    probe(6, 'h44, 1'b0, "R7 flagged line dropped");
    probe(7, 'h45, 1'b1, "R7 unflagged line kept");
    snoop(0, 7, 'h45);
    chk(viol, 1'b0, "R7 read marker cleared");
    access(9, 'h50, 1'b1);
    do_commit();
    do_restart();
    probe(9, 'h50, 1'b1, "R7 modified marker cleared");
  endtask

  task automatic t_own();
    do_restart();
    access(8, 'h55, 1'b0);
    snoop(1, 8, 'h55);
    chk(viol, 1'b0, "R9 own write no violation");
    probe(8, 'h55, 1'b1, "R9 own write keeps line");
    do_commit();
    probe(8, 'h55, 1'b1, "R9 own write set no flag");
  endtask

  task automatic t_restart();
    do_restart();
    access(9, 'h66, 1'b1);
    access(10, 'h77, 1'b0);
    access(11, 'h78, 1'b0);
    snoop(3, 11, 'h78);
    do_restart();
    probe(9, 'h66, 1'b0, "R8 modified line dropped");
    probe(10, 'h77, 1'b1, "R8 read line kept");
    probe(11, 'h78, 1'b1, "R8 flagged line kept");
    snoop(0, 10, 'h77);
    chk(viol, 1'b0, "R8 read marker cleared");
    do_commit();
    probe(11, 'h78, 1'b0, "R8 flag survives restart");
  endtask

  task automatic t_wrap();
    @(negedge clk); head_seq = 2'd2; my_seq = 2'd0;
    do_restart();
    access(12, 'h88, 1'b0);
    snoop(3, 12, 'h88);
    chk(viol, 1'b1, "R3 seq 3 older across wrap");
    do_restart();
    access(13, 'h99, 1'b0);
    snoop(1, 13, 'h99);
    chk(viol, 1'b0, "R3 seq 1 younger across wrap");
    probe(13, 'h99, 1'b1, "R3 younger keeps line");
    @(negedge clk); head_seq = 2'd0; my_seq = 2'd1;
  endtask

  task automatic t_priority();
    do_restart();
    @(negedge clk);
    restart = 1'b1; lk_valid = 1'b1; lk_store = 1'b0;
    lk_idx = IDX_W'(14); lk_tag = TAG_W'('h5a);
    @(negedge clk);
    restart = 1'b0; lk_valid = 1'b0;
    probe(14, 'h5a, 1'b0, "R11 access dropped in restart");
    access(15, 'h5b, 1'b1);
    @(negedge clk);
    restart = 1'b1; commit = 1'b1;
    @(negedge clk);
    restart = 1'b0; commit = 1'b0;
    probe(15, 'h5b, 1'b0, "R11 restart wins over commit");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_lookup();
    t_earlier();
    t_store_only();
    t_later_commit();
    t_own();
    t_restart();
    t_wrap();
    t_priority();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule